// File: doc/BRIEF.md
# Deglitched Interrupt Combiner

This block gathers one active-low interrupt request from each downstream channel and merges them into a single active-low request toward the host side. The merged line is meant to drive an open-drain pad: a low value means "pull the wire down", a high value means "release it". Each request line is asynchronous to the system clock. It passes through a two-flop synchronizer and then through a filter that rejects low pulses and high pulses below separate minimum widths. Both widths are counted in system clock cycles.

A four-bit active-high flag vector follows the filtered levels, so a flag is 1 while its channel is interrupting. The flags are not latched. When the register interface loads its read byte into the shift register, it strobes `rd_load_i`, and the block captures the flags into `snap_o`. `snap_o` forms the upper nibble of the read byte: channel n appears at bit 4+n. Channel selection plays no part here. A request is seen whether or not its channel is switched in.

Top module: `irq_combiner`

## Requirements
- R1: `irq_n_o` is 0 exactly when at least one filtered flag is 1. It is the AND of the filtered active-low channel levels.
- R2: On a channel whose filtered level is high, a low pulse at the pin shorter than `LOW_REJECT_CYC` clock cycles has no effect on `irq_n_o` or the flags. A low pulse of exactly `LOW_REJECT_CYC` cycles is accepted.
- R3: On a channel whose filtered level is low, a high pulse shorter than `HIGH_REJECT_CYC` cycles has no effect. The flag stays 1 and `irq_n_o` stays 0.
- R4: A steady low at a pin is reflected on `irq_n_o` `LOW_REJECT_CYC`+2 rising edges after the pin change. A steady high is reflected `HIGH_REJECT_CYC`+2 edges after the pin change. At the default 125 MHz settings, both latencies are within 4 µs for asserting and 2 µs for releasing.
- R5: Flag n (`flags_o[n]`) is 1 while channel n is filtered low. It returns to 0 by itself once the channel is filtered high again, so it is not latched.
- R6: On a rising edge where `rd_load_i` is 1, `snap_o` takes the value of `flags_o`. On any other edge it holds. `snap_o[n]` is read-byte bit 4+n.
- R7: After reset, every filtered level is high, so `irq_n_o`=1, `flags_o`=0 and `snap_o`=0.
- R8: Channels filter independently. A change on one channel does not alter another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_n_i | input | NUM_CH | Asynchronous active-low channel requests |
| rd_load_i | input | 1 | Read byte load strobe; captures flags |
| irq_n_o | output | 1 | Combined active-low request (open-drain control) |
| flags_o | output | NUM_CH | Live active-high filtered flags |
| snap_o | output | NUM_CH | Flags captured at read load (byte bits 7:4) |

## Verification
The hardest cases to reach are the exact threshold boundaries. A pulse one cycle shorter than a threshold must leave no trace, while a pulse of exactly the threshold length must be taken. The synchronizer delay also shifts every observation by two edges. The stimulus drives the pins on falling clock edges with widths counted in whole cycles, so a pin pulse maps one-to-one onto a synchronized pulse. A monitor counts every cycle in which `irq_n_o` shows the disturbed level during the window. A high-pulse rejection test needs the channel parked in the filtered-low state first, and the test then reopens a short high gap inside that state.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int cnt_bits(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pulse_filter.sv
module irq_pulse_filter #(
   parameter int LOW_REJECT_CYC  = 125,
   parameter int HIGH_REJECT_CYC = 63,
   parameter int CNT_W           = 7
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   output logic level_o
);
   localparam logic [CNT_W-1:0] LIM_FALL = CNT_W'(LOW_REJECT_CYC - 1);
   localparam logic [CNT_W-1:0] LIM_RISE = CNT_W'(HIGH_REJECT_CYC - 1);

   logic             state_q;
   logic [CNT_W-1:0] run_q;
   logic             differ;
   logic [CNT_W-1:0] limit;

   assign differ = (level_i != state_q);
   assign limit  = state_q ? LIM_FALL : LIM_RISE;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= 1'b1;
         run_q   <= '0;
      end else if (!differ) begin
         run_q   <= '0;
      end else if (run_q == limit) begin
         state_q <= ~state_q;
         run_q   <= '0;
      end else begin
         run_q   <= run_q + 1'b1;
      end
   end

   assign level_o = state_q;

   // R2: a fall needs a full run of low samples
   a_r2_fall_after_full_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(state_q) |-> ($past(run_q) == LIM_FALL && !$past(level_i)));
   // R3: a rise needs a full run of high samples
   a_r3_rise_after_full_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_q) |-> ($past(run_q) == LIM_RISE && $past(level_i)));
   // R2/R3: the run never exceeds the larger limit
   a_r2_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= ((LIM_FALL > LIM_RISE) ? LIM_FALL : LIM_RISE));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
   import irq_combiner_pkg::*;
#(
   parameter int NUM_CH          = 4,
   parameter int SYNC_STAGES     = 2,
   parameter int LOW_REJECT_CYC  = 125,
   parameter int HIGH_REJECT_CYC = 63
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] irq_n_i,
   input  logic              rd_load_i,
   output logic              irq_n_o,
   output logic [NUM_CH-1:0] flags_o,
   output logic [NUM_CH-1:0] snap_o
);
   localparam int CNT_W = cnt_bits(max_of(LOW_REJECT_CYC, HIGH_REJECT_CYC));

   if (NUM_CH < 1) begin : g_bad_ch
      $error("irq_combiner: NUM_CH must be positive");
   end
   if (LOW_REJECT_CYC < 1 || HIGH_REJECT_CYC < 1) begin : g_bad_thr
      $error("irq_combiner: reject widths must be at least one cycle");
   end

   logic [NUM_CH-1:0] synced;
   logic [NUM_CH-1:0] filt_n;
   logic [NUM_CH-1:0] snap_q;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .async_i (irq_n_i[ch]),
         .sync_o  (synced[ch])
      );
      irq_pulse_filter #(
         .LOW_REJECT_CYC  (LOW_REJECT_CYC),
         .HIGH_REJECT_CYC (HIGH_REJECT_CYC),
         .CNT_W           (CNT_W)
      ) u_filt (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .level_i (synced[ch]),
         .level_o (filt_n[ch])
      );
   end

   assign flags_o = ~filt_n;
   assign irq_n_o = &filt_n;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q <= '0;
      else if (rd_load_i) snap_q <= flags_o;
   end

   assign snap_o = snap_q;

   // R1: the combined line only falls when some flag is up
   a_r1_fall_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_n_o) |-> (flags_o != '0));
   // R6: the capture holds without a load strobe
   a_r6_snap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_load_i |=> $stable(snap_o));
   // R6: the capture equals the flags seen at the strobe
   a_r6_snap_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_load_i |=> (snap_o == $past(flags_o)));
endmodule

// File: tb/irq_combiner_test.sv
`timescale 1ns/1ps
module irq_combiner_test;
   localparam int NCH  = 4;
   localparam int LOWC = 125;
   localparam int HIGC = 63;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] irq_n = '1;
   logic           rd_load = 1'b0;
   logic           irq_out;
   logic [NCH-1:0] flags;
   logic [NCH-1:0] snap;

   int n_cmp = 0;
   int n_bad = 0;
   logic mon_en = 1'b0;
   int mon_low = 0;
   int mon_high = 0;

   always #4 clk = ~clk;

   irq_combiner #(.NUM_CH(NCH), .LOW_REJECT_CYC(LOWC), .HIGH_REJECT_CYC(HIGC)) uut (
      .clk_i(clk), .rst_ni(rst_n), .irq_n_i(irq_n), .rd_load_i(rd_load),
      .irq_n_o(irq_out), .flags_o(flags), .snap_o(snap)
   );

   always @(negedge clk) begin
      if (mon_en) begin
         if (!irq_out) mon_low++;
         else          mon_high++;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      check("R7 irq", {31'd0, irq_out}, 32'd1);
      check("R7 flags", {28'd0, flags}, 32'd0);
      check("R7 snap", {28'd0, snap}, 32'd0);
   endtask

   task automatic t_latency();
      irq_n[0] = 1'b0;
      step(LOWC + 1);
      check("R4 not yet low", {31'd0, irq_out}, 32'd1);
      step(1);
      check("R4 asserted", {31'd0, irq_out}, 32'd0);
      check("R5 flag0 set", {28'd0, flags}, 32'h1);
      irq_n[0] = 1'b1;
      step(HIGC + 1);
      check("R4 not yet released", {31'd0, irq_out}, 32'd0);
      step(1);
      check("R4 released", {31'd0, irq_out}, 32'd1);
      check("R5 flag0 cleared", {28'd0, flags}, 32'h0);
      check("R4 within 4us", {31'd0, ((LOWC + 2) * 8 <= 4000)}, 32'd1);
      check("R4 within 2us", {31'd0, ((HIGC + 2) * 8 <= 2000)}, 32'd1);
   endtask

   task automatic t_low_reject();
      for (int ch = 0; ch < NCH; ch++) begin
         mon_low = 0; mon_en = 1'b1;
         irq_n[ch] = 1'b0;
         step(LOWC - 1);
         irq_n[ch] = 1'b1;
         step(LOWC + 10);
         mon_en = 1'b0;
         check("R2 short low ignored", mon_low, 0);
         check("R2 flags untouched", {28'd0, flags}, 32'h0);
      end
      mon_low = 0; mon_en = 1'b1;
      irq_n[1] = 1'b0;
      step(LOWC);
      irq_n[1] = 1'b1;
      step(4);
      mon_en = 1'b0;
      check("R2 exact width taken", {31'd0, (mon_low > 0)}, 32'd1);
      step(HIGC + 10);
      check("R2 recovered", {31'd0, irq_out}, 32'd1);
   endtask

   task automatic t_high_reject();
      irq_n[2] = 1'b0;
      step(LOWC + 5);
      check("R3 parked low", {28'd0, flags}, 32'h4);
      mon_high = 0; mon_en = 1'b1;
      irq_n[2] = 1'b1;
      step(HIGC - 1);
      irq_n[2] = 1'b0;
      step(HIGC + 10);
      mon_en = 1'b0;
      check("R3 short high ignored", mon_high, 0);
      check("R3 flag kept", {28'd0, flags}, 32'h4);
      irq_n[2] = 1'b1;
      step(HIGC + 5);
      check("R3 released", {31'd0, irq_out}, 32'd1);
   endtask

   task automatic t_multi();
      irq_n[1] = 1'b0; irq_n[3] = 1'b0;
      step(LOWC + 5);
      check("R1 two sources", {28'd0, flags}, 32'hA);
      check("R1 combined low", {31'd0, irq_out}, 32'd0);
      irq_n[1] = 1'b1;
      step(HIGC + 5);
      check("R8 ch3 independent", {28'd0, flags}, 32'h8);
      check("R1 still low", {31'd0, irq_out}, 32'd0);
      irq_n[3] = 1'b1;
      step(HIGC + 5);
      check("R1 all high", {31'd0, irq_out}, 32'd1);
   endtask

   task automatic t_snap();
      irq_n[0] = 1'b0;
      step(LOWC + 5);
      rd_load = 1'b1;
      step(1);
      rd_load = 1'b0;
      check("R6 captured", {28'd0, snap}, 32'h1);
      irq_n[0] = 1'b1;
      step(HIGC + 5);
      check("R5 live flag clear", {28'd0, flags}, 32'h0);
      check("R6 held", {28'd0, snap}, 32'h1);
      rd_load = 1'b1;
      step(1);
      rd_load = 1'b0;
      check("R6 recaptured", {28'd0, snap}, 32'h0);
   endtask

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(3);
      t_reset();
      t_latency();
      t_low_reject();
      t_high_reject();
      t_multi();
      t_snap();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule